// File: doc/BRIEF.md
# Quad-Lockstep Integer Dual-Issue Lane Stage

This stage executes one integer instruction word for a group of four scalar threads (a quad) that run in lockstep. Each thread owns one 32-bit lane, and every lane obeys the same instruction word. The word carries two operations that run in the same cycle on every lane. One goes to a multiply-add unit that computes a×b+c. The other goes to an adder unit that can add, subtract or pass one of its operands through. Each unit has its own packed mode: one 32-bit element, two 16-bit elements or four 8-bit elements per lane. In the narrower modes each element is computed on its own and wraps modulo its own width.

A vector operation for a quad reaches this stage as a run of scalar issues, one component per cycle. A three-component operation therefore takes three back-to-back issues, and its results come out on three consecutive cycles. The stage never stalls. Both results are registered with one cycle of latency. A per-lane active mask lets a lane keep its previous results, and a temporary path lets the adder reuse its own last result in place of its first operand.

Top module: `quad_lane_exec`

## Requirements
- R1: After reset, and while reset is held, `out_valid` is 0 and both result buses are 0. `out_valid` is `in_valid` delayed by one clock.
- R2: The multiply-add mode field is instr[1:0]. With code 0, or the spare code 3, each active lane returns (a×b+c) mod 2^32 one cycle after issue.
- R3: With multiply-add mode code 1, each 16-bit half of a lane returns its own (a×b+c) mod 2^16. No partial product or carry crosses the half boundary.
- R4: With multiply-add mode code 2, each byte of a lane returns its own (a×b+c) mod 2^8.
- R5: The add operation is instr[5:4]: 0 gives a+b, 1 gives a−b, 2 passes a and 3 passes b. The pass operations do not depend on the mode.
- R6: The add mode is instr[3:2] and uses the same codes as the multiply-add mode. In the 16-bit and 8-bit modes no carry or borrow crosses an element boundary.
- R7: The two units use their own mode fields, and both produce results for the same issue in the same cycle.
- R8: A lane whose bit in `lane_act` is 0 keeps both of its previous results when an issue is accepted.
- R9: While `in_valid` is 0, both result buses keep their values.
- R10: When instr[6] is 1, the adder's first operand in each lane is that lane's current `ad_res` value instead of `ad_a`.
- R11: Issues on consecutive cycles are all accepted. A three-component vector issued over three cycles yields three results on three consecutive cycles.
- R12: Lane i uses bits [32i+31:32i] of every operand bus and result bus. Lanes do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An issue is present this cycle |
| instr | input | 7 | Dual-operation word: {use_tmp, add_op[1:0], add_mode[1:0], madd_mode[1:0]} |
| lane_act | input | 4 | Per-lane active mask |
| ma_a | input | 128 | Multiply-add operand a, one 32-bit slice per lane |
| ma_b | input | 128 | Multiply-add operand b, one 32-bit slice per lane |
| ma_c | input | 128 | Multiply-add addend c, one 32-bit slice per lane |
| ad_a | input | 128 | Adder operand a, one 32-bit slice per lane |
| ad_b | input | 128 | Adder operand b, one 32-bit slice per lane |
| out_valid | output | 1 | Results belong to the issue of the previous cycle |
| ma_res | output | 128 | Registered multiply-add results |
| ad_res | output | 128 | Registered adder results |

## Verification
The adder's temporary forwarding and the per-lane active mask can act on the same issue. An issue with instr[6] set can arrive right after a partly masked issue, so the forwarded value in a masked lane is a held result from an older issue. The bench provokes this by chaining several forwarding issues under changing masks. Its reference model keeps its own copy of each lane's last result, and the outputs are compared against that model one cycle after each issue.

// File: rtl/quad_pkg.sv
package quad_pkg;
    localparam int LANE_W = 32;

    typedef enum logic [1:0] {
        PK_W32 = 2'd0,
        PK_W16 = 2'd1,
        PK_W8  = 2'd2,
        PK_RSV = 2'd3
    } pack_mode_e;

    typedef enum logic [1:0] {
        AOP_ADD    = 2'd0,
        AOP_SUB    = 2'd1,
        AOP_PASS_A = 2'd2,
        AOP_PASS_B = 2'd3
    } add_op_e;

    typedef struct packed {
        logic       use_tmp;
        add_op_e    aop;
        pack_mode_e amode;
        pack_mode_e fmode;
    } dual_op_t;
endpackage

// File: rtl/qx_madd_lane.sv
module qx_madd_lane
    import quad_pkg::*;
(
    input  pack_mode_e        mode,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic [LANE_W-1:0] c,
    output logic [LANE_W-1:0] y
);
    localparam int N16 = LANE_W / 16;
    localparam int N8  = LANE_W / 8;

    logic [LANE_W-1:0] full_v;
    logic [LANE_W-1:0] half_v;
    logic [LANE_W-1:0] byte_v;

    assign full_v = a * b + c;

    for (genvar h = 0; h < N16; h++) begin : g_h16
        assign half_v[h*16 +: 16] = a[h*16 +: 16] * b[h*16 +: 16] + c[h*16 +: 16];
    end

    for (genvar k = 0; k < N8; k++) begin : g_b8
        assign byte_v[k*8 +: 8] = a[k*8 +: 8] * b[k*8 +: 8] + c[k*8 +: 8];
    end

    always_comb begin
        case (mode)
            PK_W16:  y = half_v;
            PK_W8:   y = byte_v;
            default: y = full_v;
        endcase
    end
endmodule

// File: rtl/qx_add_lane.sv
module qx_add_lane
    import quad_pkg::*;
(
    input  pack_mode_e        mode,
    input  add_op_e           op,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] y
);
    localparam int N16 = LANE_W / 16;
    localparam int N8  = LANE_W / 8;

    logic [LANE_W-1:0] s32, d32, s16, d16, s8, d8;
    logic [LANE_W-1:0] sum_sel, dif_sel;

    assign s32 = a + b;
    assign d32 = a - b;

    for (genvar h = 0; h < N16; h++) begin : g_h16
        assign s16[h*16 +: 16] = a[h*16 +: 16] + b[h*16 +: 16];
        assign d16[h*16 +: 16] = a[h*16 +: 16] - b[h*16 +: 16];
    end

    for (genvar k = 0; k < N8; k++) begin : g_b8
        assign s8[k*8 +: 8] = a[k*8 +: 8] + b[k*8 +: 8];
        assign d8[k*8 +: 8] = a[k*8 +: 8] - b[k*8 +: 8];
    end

    always_comb begin
        case (mode)
            PK_W16: begin
                sum_sel = s16;
                dif_sel = d16;
            end
            PK_W8: begin
                sum_sel = s8;
                dif_sel = d8;
            end
            default: begin
                sum_sel = s32;
                dif_sel = d32;
            end
        endcase
        case (op)
            AOP_SUB:    y = dif_sel;
            AOP_PASS_A: y = a;
            AOP_PASS_B: y = b;
            default:    y = sum_sel;
        endcase
    end
endmodule

// File: rtl/quad_lane_exec.sv
module quad_lane_exec
    import quad_pkg::*;
#(
    parameter  int LANES   = 4,
    localparam int VEC_W   = LANES * LANE_W,
    localparam int INSTR_W = $bits(dual_op_t)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [LANES-1:0]   lane_act,
    input  logic [VEC_W-1:0]   ma_a,
    input  logic [VEC_W-1:0]   ma_b,
    input  logic [VEC_W-1:0]   ma_c,
    input  logic [VEC_W-1:0]   ad_a,
    input  logic [VEC_W-1:0]   ad_b,
    output logic               out_valid,
    output logic [VEC_W-1:0]   ma_res,
    output logic [VEC_W-1:0]   ad_res
);
    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] ma;
        logic [VEC_W-1:0] ad;
    } stage_t;

    dual_op_t         op;
    stage_t           st_d, st_q;
    logic [VEC_W-1:0] ma_y, ad_y, ad_src_a;

    assign op = dual_op_t'(instr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign ad_src_a[l*LANE_W +: LANE_W] = op.use_tmp ? st_q.ad[l*LANE_W +: LANE_W]
                                                         : ad_a[l*LANE_W +: LANE_W];

        qx_madd_lane u_madd (
            .mode (op.fmode),
            .a    (ma_a[l*LANE_W +: LANE_W]),
            .b    (ma_b[l*LANE_W +: LANE_W]),
            .c    (ma_c[l*LANE_W +: LANE_W]),
            .y    (ma_y[l*LANE_W +: LANE_W])
        );

        qx_add_lane u_add (
            .mode (op.amode),
            .op   (op.aop),
            .a    (ad_src_a[l*LANE_W +: LANE_W]),
            .b    (ad_b[l*LANE_W +: LANE_W]),
            .y    (ad_y[l*LANE_W +: LANE_W])
        );

        // R8
        hold_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !lane_act[l]) |=>
                ($stable(ma_res[l*LANE_W +: LANE_W]) && $stable(ad_res[l*LANE_W +: LANE_W])));
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        for (int l = 0; l < LANES; l++) begin
            if (in_valid && lane_act[l]) begin
                st_d.ma[l*LANE_W +: LANE_W] = ma_y[l*LANE_W +: LANE_W];
                st_d.ad[l*LANE_W +: LANE_W] = ad_y[l*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign ma_res    = st_q.ma;
    assign ad_res    = st_q.ad;

    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(ma_res) && $stable(ad_res)));

    // R5
    pass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_act[0] && op.aop == AOP_PASS_B) |=>
            ad_res[LANE_W-1:0] == $past(ad_b[LANE_W-1:0]));

    // R10
    tmp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_act[0] && op.use_tmp && op.aop == AOP_PASS_A) |=>
            $stable(ad_res[LANE_W-1:0]));

    // R2
    madd_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_act[0] && op.fmode == PK_W32) |=>
            ma_res[LANE_W-1:0] == $past(ma_a[LANE_W-1:0] * ma_b[LANE_W-1:0] + ma_c[LANE_W-1:0]));
endmodule

// File: tb/quad_lane_exec_tb.sv
module quad_lane_exec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int VW = NL * 32;

    typedef struct packed {
        logic [6:0]  ins;
        logic [3:0]  act;
        logic [31:0] sa;
        logic [31:0] sb;
        logic [31:0] sc;
        logic [7:0]  tag;
    } vec_t;

    // instr = {use_tmp, add_op, add_mode, madd_mode}
    localparam vec_t TBL [10] = '{
        '{7'b0_00_00_00, 4'hF, 32'h1234_5678, 32'h0000_0003, 32'h0000_0010, 8'd2},  // R2 add32
        '{7'b0_01_01_01, 4'hF, 32'h7FFF_8001, 32'h0003_0002, 32'hFFFF_0001, 8'd3},  // R3 sub16
        '{7'b0_00_10_10, 4'hF, 32'h80FF_7F10, 32'h0203_0405, 32'h0101_FF01, 8'd4},  // R4 add8
        '{7'b0_10_00_10, 4'hF, 32'hDEAD_BEEF, 32'h1111_1111, 32'h2222_2222, 8'd5},  // R5 pass a
        '{7'b0_11_10_01, 4'hF, 32'hCAFE_0001, 32'h0000_FFFF, 32'h0F0F_0F0F, 8'd5},  // R5 pass b
        '{7'b0_00_11_11, 4'hF, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0003, 8'd2},  // R2 spare code
        '{7'b0_00_10_10, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0101_0101, 8'd6},  // R6 byte carry
        '{7'b0_01_01_00, 4'hF, 32'h0000_0000, 32'h0001_0001, 32'h0001_0001, 8'd6},  // R6 half borrow
        '{7'b0_01_10_01, 4'hF, 32'h00FF_00FF, 32'h0101_0101, 32'h0100_0001, 8'd7},  // R7 mixed modes
        '{7'b0_00_01_10, 4'hF, 32'hA5A5_5A5A, 32'h0F00_F00F, 32'h1357_9BDF, 8'd12}  // R12 per lane
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [6:0]    instr = '0;
    logic [NL-1:0] lane_act = '0;
    logic [VW-1:0] ma_a = '0, ma_b = '0, ma_c = '0, ad_a = '0, ad_b = '0;
    logic          out_valid;
    logic [VW-1:0] ma_res, ad_res;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic [31:0] exp_ma [NL];
    logic [31:0] exp_ad [NL];
    logic        exp_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_lane_exec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .lane_act(lane_act),
        .ma_a(ma_a), .ma_b(ma_b), .ma_c(ma_c), .ad_a(ad_a), .ad_b(ad_b),
        .out_valid(out_valid), .ma_res(ma_res), .ad_res(ad_res)
    );

    function automatic logic [31:0] mix(input logic [31:0] s, input int i, input int salt);
        return s ^ (32'h9E37_79B9 * 32'(i * 7 + salt)) ^ (32'h0000_0101 * 32'(i));
    endfunction

    function automatic int ew_of(input logic [1:0] md);
        return (md == 2'd1) ? 16 : (md == 2'd2) ? 8 : 32;
    endfunction

    function automatic logic [31:0] ref_madd(input logic [1:0] md, input logic [31:0] a, b, c);
        int ew = ew_of(md);
        logic [63:0] mask = (64'd1 << ew) - 64'd1;
        logic [63:0] r = 64'd0;
        for (int k = 0; k < 32 / ew; k++) begin
            logic [63:0] x, y, z, e;
            x = ({32'd0, a} >> (k * ew)) & mask;
            y = ({32'd0, b} >> (k * ew)) & mask;
            z = ({32'd0, c} >> (k * ew)) & mask;
            e = (x * y + z) & mask;
            r = r | (e << (k * ew));
        end
        return r[31:0];
    endfunction

    function automatic logic [31:0] ref_add(input logic [1:0] md, input logic [1:0] op,
                                            input logic [31:0] a, b);
        int ew = ew_of(md);
        logic [63:0] mask = (64'd1 << ew) - 64'd1;
        logic [63:0] r = 64'd0;
        if (op == 2'd2) return a;
        if (op == 2'd3) return b;
        for (int k = 0; k < 32 / ew; k++) begin
            logic [63:0] x, y, e;
            x = ({32'd0, a} >> (k * ew)) & mask;
            y = ({32'd0, b} >> (k * ew)) & mask;
            e = ((op == 2'd1) ? (x - y) : (x + y)) & mask;
            r = r | (e << (k * ew));
        end
        return r[31:0];
    endfunction

    task automatic chk(input bit ok, input int tag, input string what,
                       input logic [VW-1:0] got, input logic [VW-1:0] want);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s got=%h exp=%h", tag, what, got, want);
        end
    endtask

    task automatic compare(input int tag);
        logic [VW-1:0] em, ea;
        for (int i = 0; i < NL; i++) begin
            em[i*32 +: 32] = exp_ma[i];
            ea[i*32 +: 32] = exp_ad[i];
        end
        chk(out_valid === exp_v, tag, "valid", {{(VW-1){1'b0}}, out_valid}, {{(VW-1){1'b0}}, exp_v});
        chk(ma_res === em, tag, "madd", ma_res, em);
        chk(ad_res === ea, tag, "add", ad_res, ea);
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic step(input logic [6:0] ins, input logic [3:0] act, input logic v,
                        input logic [31:0] sa, sb, sc, input int tag);
        instr    = ins;
        lane_act = act;
        in_valid = v;
        for (int i = 0; i < NL; i++) begin
            logic [31:0] a, b, c, x, y, xe;
            a = mix(sa, i, 1);
            b = mix(sb, i, 2);
            c = mix(sc, i, 3);
            x = mix(sa, i, 4);
            y = mix(sc, i, 5);
            ma_a[i*32 +: 32] = a;
            ma_b[i*32 +: 32] = b;
            ma_c[i*32 +: 32] = c;
            ad_a[i*32 +: 32] = x;
            ad_b[i*32 +: 32] = y;
            xe = ins[6] ? exp_ad[i] : x;
            if (v && act[i]) begin
                exp_ma[i] = ref_madd(ins[1:0], a, b, c);
                exp_ad[i] = ref_add(ins[3:2], ins[5:4], xe, y);
            end
        end
        exp_v = v;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic clear_model();
        for (int i = 0; i < NL; i++) begin
            exp_ma[i] = '0;
            exp_ad[i] = '0;
        end
        exp_v = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        compare(1);  // R1 reset state
        rst_n = 1'b1;

        for (int t = 0; t < 10; t++) begin
            step(TBL[t].ins, TBL[t].act, 1'b1, TBL[t].sa, TBL[t].sb, TBL[t].sc, int'(TBL[t].tag));
        end

        // R9: idle cycles with fresh operands must not move results
        step(7'b0_00_00_00, 4'hF, 1'b0, 32'h5555_AAAA, 32'h3333_CCCC, 32'h0F0F_F0F0, 9);
        step(7'b0_01_10_10, 4'hF, 1'b0, 32'h0123_4567, 32'h89AB_CDEF, 32'h1111_0000, 9);

        // R8: partial masks
        step(7'b0_00_00_00, 4'b0101, 1'b1, 32'h1111_2222, 32'h0000_0005, 32'h0000_0007, 8);
        step(7'b0_01_01_01, 4'b1000, 1'b1, 32'h9999_8888, 32'h0002_0003, 32'h4444_5555, 8);
        step(7'b0_00_10_10, 4'b0000, 1'b1, 32'h7777_6666, 32'h0101_0101, 32'h3333_2222, 8);

        // R10: temporary chaining combined with masks
        step(7'b1_00_00_00, 4'hF,    1'b1, 32'h0000_1000, 32'h0000_0001, 32'h0000_0100, 10);
        step(7'b1_00_10_00, 4'b0011, 1'b1, 32'h0000_2000, 32'h0000_0002, 32'h0000_0200, 10);
        step(7'b1_01_01_00, 4'b1110, 1'b1, 32'h0000_3000, 32'h0000_0003, 32'h0000_0300, 10);
        step(7'b1_10_00_00, 4'hF,    1'b1, 32'h0000_4000, 32'h0000_0004, 32'h0000_0400, 10);

        // R11: three-component vector over three back-to-back issues
        step(7'b0_00_00_00, 4'hF, 1'b1, 32'h0000_0011, 32'h0000_0002, 32'h0000_0001, 11);
        step(7'b0_00_00_00, 4'hF, 1'b1, 32'h0000_0022, 32'h0000_0003, 32'h0000_0002, 11);
        step(7'b0_00_00_00, 4'hF, 1'b1, 32'h0000_0033, 32'h0000_0004, 32'h0000_0003, 11);

        // R1: reset in mid-run clears outputs at once
        rst_n = 1'b0;
        #1;
        clear_model();
        compare(1);
        @(negedge clk);
        rst_n = 1'b1;
        step(7'b0_11_00_01, 4'hF, 1'b1, 32'hFEED_F00D, 32'h0004_0004, 32'h0002_0002, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule